// File: doc/BRIEF.md
# Phase-Error Lock Watch with Violation Stretching

This block watches the up and down pulses of a phase-frequency detector and decides whether the surrounding PLL counts as locked. A 2-bit mode input picks the behaviour. In stopped mode the detector asserts nothing and does not drive its status line. In pass-through mode the raw phase error is forwarded to the unlock output. In the two measuring modes the block counts sampling-clock cycles while the error is present. Any error pulse that lasts longer than the selected threshold is treated as a violation. A violation holds the unlock output high for a long time, so that firmware polling a slow status pin or bit still sees it.

The thresholds and the hold time are given in physical units (nanoseconds and microseconds). They are turned into cycle counts from the sampling clock frequency at elaboration, always rounding up. With the defaults (7200 kHz sampling clock, 550 ns and 1110 ns thresholds, 1500 us hold) the cycle counts are 4, 8 and 10800.

Top module: `lock_watch`

## Requirements
- R1: With mode 00 the block is stopped: `unlock_o` is 0, `drive_en_o` is 0 and `locked_o` is 1, whatever `up_i` and `dn_i` do.
- R2: With mode 01, and the mode unchanged since the previous clock edge, `unlock_o` equals `up_i | dn_i` in the same cycle, with no width test.
- R3: With mode 10, an error (`up_i | dn_i` high) counts as a violation at the clock edge where it has been sampled high for more than NARROW_CYC consecutive edges, NARROW_CYC = ceil(f_kHz x 550 / 10^6) (4 by default, so the 5th consecutive high edge violates).
- R4: With mode 11 the same rule applies with WIDE_CYC = ceil(f_kHz x 1110 / 10^6) (8 by default, so the 9th consecutive high edge violates).
- R5: From the edge that samples a violation, `unlock_o` is high for exactly HOLD_CYC = ceil(f_kHz x 1500 / 1000) cycles (10800 by default) if no further violation occurs.
- R6: Every violation edge reloads the full hold time, so repeated or continuing violations keep `unlock_o` high until HOLD_CYC cycles after the last one.
- R7: `locked_o` is always the inverse of `unlock_o`, and `drive_en_o` is 1 in every mode except 00.
- R8: The width count restarts whenever `up_i` and `dn_i` are both low at an edge, so short pulses separated by a low cycle never add up to a violation.
- R9: In a cycle where `mode_i` differs from the mode sampled at the previous edge, `unlock_o` is 0. At that edge the hold time and the width count are cleared.
- R10: While and after reset (`rst_ni` low, asynchronous), the hold time and width count are zero, the previous mode reads as 00 and `unlock_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock of known frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Phase error pulse, reference leading |
| dn_i | input | 1 | Phase error pulse, feedback leading |
| mode_i | input | 2 | 00 stopped, 01 pass-through, 10 narrow threshold, 11 wide threshold |
| unlock_o | output | 1 | Unlock indication for the status pin (active high) |
| drive_en_o | output | 1 | Status pin drive enable; 0 means the pin is left open |
| locked_o | output | 1 | Readable lock status, 0 while unlocked |

## Verification
The assertions assume that `up_i`, `dn_i` and `mode_i` are synchronous to the sampling clock and settle well before each rising edge. The pass-through and mode-change checks also assume that the previous edge was outside reset. The stimulus changes every input only on the falling edge and compares one time unit later. Reset is released on a falling edge. Pulse widths are placed just at and just above each threshold, and the mode is switched while a hold is running.

// File: rtl/lock_watch_pkg.sv
package lock_watch_pkg;

   typedef enum logic [1:0] {
      LW_STOP   = 2'b00,
      LW_PASS   = 2'b01,
      LW_NARROW = 2'b10,
      LW_WIDE   = 2'b11
   } lw_mode_e;

   function automatic longint unsigned lw_ceil_div(input longint unsigned num,
                                                   input longint unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned lw_bits(input longint unsigned max_val);
      int unsigned b;
      b = 1;
      while ((longint'(1) << b) <= max_val) b++;
      return b;
   endfunction

endpackage

// File: rtl/lock_watch_width.sv
module lock_watch_width #(
   parameter int unsigned NARROW_CYC = 4,
   parameter int unsigned WIDE_CYC   = 8,
   parameter int unsigned CNT_W      = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic err_i,
   input  logic arm_i,
   input  logic wide_i,
   output logic viol_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       over;

   for (genvar g = 0; g < 2; g++) begin : g_cmp
      localparam int unsigned LIM = (g == 0) ? NARROW_CYC : WIDE_CYC;
      assign over[g] = (cnt_q >= CNT_W'(LIM));
   end

   assign viol_o = arm_i & err_i & over[wide_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!arm_i || !err_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lock_watch_hold.sv
module lock_watch_hold #(
   parameter int unsigned HOLD_CYC = 10800,
   parameter int unsigned HOLD_W   = 14
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              load_i,
   output logic              active_o,
   output logic [HOLD_W-1:0] count_o
);
   if (HOLD_CYC == 1) begin : g_flop
      logic act_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     act_q <= 1'b0;
         else if (clr_i)  act_q <= 1'b0;
         else             act_q <= load_i;
      end
      assign active_o = act_q;
      assign count_o  = HOLD_W'(act_q);
   end else begin : g_count
      logic [HOLD_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)            cnt_q <= '0;
         else if (clr_i)         cnt_q <= '0;
         else if (load_i)        cnt_q <= HOLD_W'(HOLD_CYC);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign active_o = (cnt_q != '0);
      assign count_o  = cnt_q;
   end
endmodule

// File: rtl/lock_watch.sv
module lock_watch
   import lock_watch_pkg::*;
#(
   parameter int unsigned CLK_KHZ   = 7200,
   parameter int unsigned NARROW_NS = 550,
   parameter int unsigned WIDE_NS   = 1110,
   parameter int unsigned HOLD_US   = 1500
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       up_i,
   input  logic       dn_i,
   input  logic [1:0] mode_i,
   output logic       unlock_o,
   output logic       drive_en_o,
   output logic       locked_o
);
   localparam int unsigned NARROW_CYC =
      int'(lw_ceil_div(longint'(CLK_KHZ) * NARROW_NS, 1000000));
   localparam int unsigned WIDE_CYC =
      int'(lw_ceil_div(longint'(CLK_KHZ) * WIDE_NS, 1000000));
   localparam int unsigned HOLD_CYC =
      int'(lw_ceil_div(longint'(CLK_KHZ) * HOLD_US, 1000));
   localparam int unsigned MAX_THR = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
   localparam int unsigned CNT_W   = lw_bits(MAX_THR + 1);
   localparam int unsigned HOLD_W  = lw_bits(HOLD_CYC);

   initial begin
      assert (CLK_KHZ > 0)    else $error("lock_watch: CLK_KHZ must be nonzero");
      assert (NARROW_CYC > 0) else $error("lock_watch: narrow threshold rounds to zero");
      assert (WIDE_CYC > 0)   else $error("lock_watch: wide threshold rounds to zero");
      assert (HOLD_CYC > 0)   else $error("lock_watch: hold time rounds to zero");
   end

   lw_mode_e          mode_q;
   lw_mode_e          mode_now;
   logic              same;
   logic              err;
   logic              arm;
   logic              viol;
   logic              hold_act;
   logic [HOLD_W-1:0] hold_cnt;

   assign mode_now = lw_mode_e'(mode_i);
   assign same     = (mode_now == mode_q);
   assign err      = up_i | dn_i;
   assign arm      = same & mode_i[1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= LW_STOP;
      else         mode_q <= mode_now;
   end

   lock_watch_width #(
      .NARROW_CYC (NARROW_CYC),
      .WIDE_CYC   (WIDE_CYC),
      .CNT_W      (CNT_W)
   ) u_width (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .err_i  (err),
      .arm_i  (arm),
      .wide_i (mode_i[0]),
      .viol_o (viol)
   );

   lock_watch_hold #(
      .HOLD_CYC (HOLD_CYC),
      .HOLD_W   (HOLD_W)
   ) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (!same),
      .load_i   (viol),
      .active_o (hold_act),
      .count_o  (hold_cnt)
   );

   always_comb begin
      unlock_o = 1'b0;
      if (same) begin
         unique case (mode_now)
            LW_STOP:   unlock_o = 1'b0;
            LW_PASS:   unlock_o = err;
            LW_NARROW,
            LW_WIDE:   unlock_o = hold_act;
            default:   unlock_o = 1'b0;
         endcase
      end
   end

   assign drive_en_o = (mode_now != LW_STOP);
   assign locked_o   = ~unlock_o;
endmodule

// File: rtl/lock_watch_chk.sv
module lock_watch_chk #(
   parameter int unsigned HOLD_CYC = 10800,
   parameter int unsigned HOLD_W   = 14
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              up_i,
   input logic              dn_i,
   input logic [1:0]        mode_i,
   input logic              unlock_o,
   input logic              drive_en_o,
   input logic              locked_o,
   input logic              viol,
   input logic              same,
   input logic [HOLD_W-1:0] hold_cnt
);
   a_r1_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00) |-> (!unlock_o && !drive_en_o && locked_o));

   a_r2_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && mode_i == 2'b01 && $past(mode_i) == 2'b01)
         |-> (unlock_o == (up_i | dn_i)));

   a_r9_mode_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && mode_i != $past(mode_i)) |-> !unlock_o);

   a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol |=> (hold_cnt == HOLD_W'(HOLD_CYC)));

   a_r5_decay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_cnt != '0 && !viol && same) |=> (hold_cnt == $past(hold_cnt) - 1'b1));

   a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_cnt <= HOLD_W'(HOLD_CYC));

   a_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[1] && same && hold_cnt != '0) |-> (unlock_o && !locked_o));
endmodule

bind lock_watch lock_watch_chk #(
   .HOLD_CYC (HOLD_CYC),
   .HOLD_W   (HOLD_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .up_i       (up_i),
   .dn_i       (dn_i),
   .mode_i     (mode_i),
   .unlock_o   (unlock_o),
   .drive_en_o (drive_en_o),
   .locked_o   (locked_o),
   .viol       (viol),
   .same       (same),
   .hold_cnt   (hold_cnt)
);

// File: tb/test_lock_watch.sv
`timescale 1ns/1ps
module test_lock_watch;
   localparam int F_KHZ = 7200;
   localparam int EXP_N = (F_KHZ * 550 + 999999) / 1000000;   // 4
   localparam int EXP_W = (F_KHZ * 1110 + 999999) / 1000000;  // 8
   localparam int EXP_H = (F_KHZ * 1500 + 999) / 1000;       // 10800

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up = 1'b0, dn = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       unlock, drv, locked;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit finished = 0;

   // reference model state
   int m_run = 0, m_hold = 0;
   logic [1:0] m_prev = 2'b00;

   always #5 clk = ~clk;

   lock_watch #(.CLK_KHZ(F_KHZ)) i_lock_watch (
      .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .mode_i(mode),
      .unlock_o(unlock), .drive_en_o(drv), .locked_o(locked));

   task automatic compare(input string tag);
      logic exp_u;
      logic err;
      err = up | dn;
      exp_u = 1'b0;
      if (rst_n && mode == m_prev) begin
         if (mode == 2'b01)   exp_u = err;
         else if (mode[1])    exp_u = (m_hold != 0);
      end
      n_cmp++;
      if (unlock !== exp_u || locked !== !exp_u || drv !== (mode != 2'b00)) begin
         n_bad++;
         $display("FAIL %s cycle %0d: unlock/locked/drv got %b%b%b expected %b%b%b",
                  tag, cycles, unlock, locked, drv, exp_u, !exp_u, (mode != 2'b00));
      end
   endtask

   task automatic model_edge();
      logic chg, err, v;
      int thr;
      chg = (mode != m_prev);
      err = up | dn;
      thr = mode[0] ? EXP_W : EXP_N;
      v = !chg && mode[1] && err && (m_run >= thr);
      if (chg || !mode[1] || !err) m_run = 0; else m_run++;
      if (chg)             m_hold = 0;
      else if (v)          m_hold = EXP_H;
      else if (m_hold > 0) m_hold--;
      m_prev = mode;
   endtask

   task automatic step(input logic u, input logic d, input logic [1:0] m, input string tag);
      @(negedge clk);
      up = u; dn = d; mode = m;
      #1 compare(tag);
      @(posedge clk);
      if (rst_n) model_edge();
   endtask

   task automatic run(input int n, input logic u, input logic d,
                      input logic [1:0] m, input string tag);
      for (int i = 0; i < n; i++) step(u, d, m, tag);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         n_bad++;
         $display("FAIL watchdog: cycles %0d expected below 200000", cycles);
         summary();
      end
   end

   initial begin
      // R10 reset state
      run(3, 1'b1, 1'b0, 2'b00, "R10 reset");
      @(negedge clk); rst_n = 1'b1;
      run(3, 1'b0, 1'b0, 2'b00, "R10 after reset");
      // R1 stopped mode ignores errors
      run(20, 1'b1, 1'b0, 2'b00, "R1 stopped up");
      run(5, 1'b0, 1'b1, 2'b00, "R1 stopped dn");
      // R2 pass-through
      for (int k = 0; k < 6; k++) begin
         run(k + 1, 1'b1, 1'b0, 2'b01, "R2 pass up");
         run(2, 1'b0, 1'b0, 2'b01, "R2 pass idle");
         run(1, 1'b0, 1'b1, 2'b01, "R2 pass dn");
      end
      // R3 narrow: 4 high no violation, R8 split pulses no violation
      run(3, 1'b0, 1'b0, 2'b10, "R9 enter narrow");
      run(EXP_N, 1'b1, 1'b0, 2'b10, "R3 narrow at limit");
      run(2, 1'b0, 1'b0, 2'b10, "R3 narrow gap");
      run(3, 1'b1, 1'b0, 2'b10, "R8 split a");
      run(1, 1'b0, 1'b0, 2'b10, "R8 split gap");
      run(3, 1'b0, 1'b1, 2'b10, "R8 split b");
      run(2, 1'b0, 1'b0, 2'b10, "R8 idle");
      // R3 violation and R5 full hold expiry
      run(EXP_N + 1, 1'b0, 1'b1, 2'b10, "R3 narrow violation");
      run(EXP_H + 20, 1'b0, 1'b0, 2'b10, "R5 hold expiry");
      // R4 wide
      run(3, 1'b0, 1'b0, 2'b11, "R9 enter wide");
      run(EXP_W, 1'b1, 1'b0, 2'b11, "R4 wide at limit");
      run(3, 1'b0, 1'b0, 2'b11, "R4 wide gap");
      run(EXP_W + 3, 1'b1, 1'b0, 2'b11, "R4 wide violation");
      // R6 reload mid-hold
      run(5000, 1'b0, 1'b0, 2'b11, "R6 hold running");
      run(EXP_W + 1, 1'b0, 1'b1, 2'b11, "R6 reload");
      run(EXP_H + 10, 1'b0, 1'b0, 2'b11, "R6 hold after reload");
      // R9 mode change during hold
      run(EXP_W + 2, 1'b1, 1'b0, 2'b11, "R9 arm wide");
      run(100, 1'b0, 1'b0, 2'b11, "R9 hold before change");
      run(1, 1'b0, 1'b0, 2'b10, "R9 change cycle");
      run(20, 1'b0, 1'b0, 2'b10, "R9 after change");
      // R7 drive enable across modes, R9 change to pass with error present
      run(2, 1'b1, 1'b0, 2'b01, "R7 to pass");
      run(2, 1'b1, 1'b0, 2'b00, "R7 to stop");
      // R10 reset mid-hold
      run(EXP_N + 2, 1'b1, 1'b0, 2'b10, "R10 arm narrow");
      @(negedge clk); rst_n = 1'b0;
      m_run = 0; m_hold = 0; m_prev = 2'b00;
      run(2, 1'b0, 1'b0, 2'b10, "R10 reset mid-hold");
      @(negedge clk); rst_n = 1'b1;
      run(5, 1'b0, 1'b0, 2'b10, "R10 released");
      summary();
   end
endmodule